// File: doc/BRIEF.md
# Per-Element Lock Flag Bank

This block keeps a single mutual-exclusion flag for each of the processor elements in a multi-threaded array. The execute unit presents at most one lock-related request per cycle: the index of the element doing the executing, a two-bit request kind and the 32-bit instruction operand. The block answers in the same cycle with a branch-taken indication. That indication is derived from the flag value held *before* the request. Any flag change then appears after the next rising clock edge.

A flag can only ever be raised by the element that owns it. To raise it, that element executes LOCK or TRYLOCK, and both leave the flag set. The two requests differ only in how they report the earlier state. TRYLOCK branches when the flag was clear, which means the caller has just acquired the lock. LOCK branches when the flag was already set. Clearing works differently: any element may clear the flags of any group of elements with UNLOCK, by naming them in a bitmask in the operand. The whole flag vector is exposed as an output so that neighbouring logic can observe ownership.

Top module: `pe_lock_bank`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `flags_o` is 0 after that edge.
- R2: A LOCK request (`req_i` = 2'b01) from element k sets `flags_o[k]` after the next rising edge and leaves every other flag unchanged.
- R3: A TRYLOCK request (`req_i` = 2'b10) from element k sets `flags_o[k]` after the next rising edge and leaves every other flag unchanged.
- R4: During a TRYLOCK request, `taken_o` is 1 in that same cycle exactly when `flags_o[k]` was 0 before the request.
- R5: During a LOCK request, `taken_o` is 1 in that same cycle exactly when `flags_o[k]` was 1 before the request.
- R6: An UNLOCK request (`req_i` = 2'b11) clears `flags_o[i]` for every i where operand bit i (bits 15..0) is 1. It leaves the other flags unchanged and holds `taken_o` at 0. This applies whichever element issues the request.
- R7: During UNLOCK, operand bits 31..16 have no effect on any flag.
- R8: With no request (`req_i` = 2'b00), `taken_o` is 0 and all flags hold their value, whatever the core index and operand are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 2 | Request kind: 00 none, 01 LOCK, 10 TRYLOCK, 11 UNLOCK |
| core_i | input | 4 | Index of the executing element |
| operand_i | input | 32 | Instruction operand; bits 15..0 form the UNLOCK mask |
| taken_o | output | 1 | Branch-taken indication for the current request |
| flags_o | output | 16 | Lock flag of every element, bit i belongs to element i |

## Verification
The bench checks the polarity of both set requests against a flag that is already held. A design that swapped the LOCK and TRYLOCK conditions, or that computed `taken_o` from the updated flag instead of the old one, would branch on the wrong cycle. UNLOCK is tested in three ways: issued by an element that does not own the cleared flag, issued with only the upper operand half set, and issued by an owner clearing its own flag. A design that let UNLOCK set the issuer's flag, or that took its mask from the wrong operand half, would leave the flag vector wrong. The bench also drives an idle request with a busy operand and applies a reset in the middle of the run, which exposes any flag that leaks or survives reset.

// File: rtl/pe_lock_pkg.sv
package pe_lock_pkg;

    localparam int unsigned PE_COUNT = 16;
    localparam int unsigned OPND_W   = 32;

    typedef enum logic [1:0] {
        RQ_IDLE    = 2'b00,
        RQ_LOCK    = 2'b01,
        RQ_TRYLOCK = 2'b10,
        RQ_UNLOCK  = 2'b11
    } lock_req_e;

    // Flag-change intent produced by the decoder for one cycle
    typedef struct packed {
        logic [PE_COUNT-1:0] raise;
        logic [PE_COUNT-1:0] drop;
    } flag_update_t;

    function automatic logic [PE_COUNT-1:0] onehot_of(input int unsigned idx);
        logic [PE_COUNT-1:0] v;
        v = '0;
        for (int unsigned b = 0; b < PE_COUNT; b++) begin
            if (b == idx) v[b] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/pe_lock_decode.sv
module pe_lock_decode
    import pe_lock_pkg::*;
#(
    parameter int unsigned NUM_PE = PE_COUNT,
    parameter int unsigned OP_W   = OPND_W,
    localparam int unsigned IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  lock_req_e           req,
    input  logic [IDX_W-1:0]    core_idx,
    input  logic [OP_W-1:0]     operand,
    output logic [NUM_PE-1:0]   raise_vec,
    output logic [NUM_PE-1:0]   drop_vec
);

    logic [NUM_PE-1:0] self_bit;

    always_comb begin
        self_bit = '0;
        for (int unsigned b = 0; b < NUM_PE; b++) begin
            if (b == 32'(core_idx)) self_bit[b] = 1'b1;
        end
    end

    always_comb begin
        raise_vec = '0;
        drop_vec  = '0;
        unique case (req)
            RQ_LOCK, RQ_TRYLOCK: raise_vec = self_bit;
            RQ_UNLOCK:           drop_vec  = operand[NUM_PE-1:0];
            default: ;
        endcase
    end

    // R2
    raise_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(raise_vec));

    // R6
    unlock_no_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (req == RQ_UNLOCK) |-> (raise_vec == '0));

endmodule

// File: rtl/pe_lock_flags.sv
module pe_lock_flags
    import pe_lock_pkg::*;
#(
    parameter int unsigned NUM_PE = PE_COUNT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PE-1:0]   raise_vec,
    input  logic [NUM_PE-1:0]   drop_vec,
    output logic [NUM_PE-1:0]   flags
);

    // One flip-flop per element; a raise outranks a drop of the same bit
    for (genvar g = 0; g < NUM_PE; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)               flags[g] <= 1'b0;
            else if (raise_vec[g]) flags[g] <= 1'b1;
            else if (drop_vec[g])  flags[g] <= 1'b0;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flags == '0));

    // R3
    raise_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (|raise_vec) |=> ((flags & $past(raise_vec)) == $past(raise_vec)));

    // R6
    drop_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (|drop_vec) |=> ((flags & $past(drop_vec & ~raise_vec)) == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (raise_vec == '0 && drop_vec == '0) |=> $stable(flags));

endmodule

// File: rtl/pe_lock_branch.sv
module pe_lock_branch
    import pe_lock_pkg::*;
#(
    parameter int unsigned NUM_PE = PE_COUNT,
    localparam int unsigned IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  lock_req_e           req,
    input  logic [IDX_W-1:0]    core_idx,
    input  logic [NUM_PE-1:0]   flags,
    output logic                taken
);

    logic own_flag;

    always_comb begin
        own_flag = 1'b0;
        for (int unsigned b = 0; b < NUM_PE; b++) begin
            if (b == 32'(core_idx)) own_flag = flags[b];
        end
    end

    always_comb begin
        unique case (req)
            RQ_TRYLOCK: taken = ~own_flag;
            RQ_LOCK:    taken = own_flag;
            default:    taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/pe_lock_bank.sv
module pe_lock_bank
    import pe_lock_pkg::*;
#(
    parameter int unsigned NUM_PE = PE_COUNT,
    parameter int unsigned OP_W   = OPND_W,
    localparam int unsigned IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          req_i,
    input  logic [IDX_W-1:0]    core_i,
    input  logic [OP_W-1:0]     operand_i,
    output logic                taken_o,
    output logic [NUM_PE-1:0]   flags_o
);

    lock_req_e    req_kind;
    flag_update_t upd;

    assign req_kind = lock_req_e'(req_i);

    pe_lock_decode #(.NUM_PE(NUM_PE), .OP_W(OP_W)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .req       (req_kind),
        .core_idx  (core_i),
        .operand   (operand_i),
        .raise_vec (upd.raise),
        .drop_vec  (upd.drop)
    );

    pe_lock_flags #(.NUM_PE(NUM_PE)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .raise_vec (upd.raise),
        .drop_vec  (upd.drop),
        .flags     (flags_o)
    );

    pe_lock_branch #(.NUM_PE(NUM_PE)) u_branch (
        .req       (req_kind),
        .core_idx  (core_i),
        .flags     (flags_o),
        .taken     (taken_o)
    );

    // R4
    trylock_free_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i == 2'b10 && !flags_o[core_i]) |-> taken_o);

    // R5
    lock_held_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i == 2'b01) |-> (taken_o == flags_o[core_i]));

    // R8
    idle_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i == 2'b00 || req_i == 2'b11) |-> !taken_o);

    // R2
    lock_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i == 2'b01) |=> flags_o[$past(core_i)]);

endmodule

// File: tb/pe_lock_bank_bench.sv
module pe_lock_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  req_i = 2'b00;
    logic [3:0]  core_i = '0;
    logic [31:0] operand_i = '0;
    logic        taken_o;
    logic [15:0] flags_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pe_lock_bank u_pe_lock_bank (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .core_i    (core_i),
        .operand_i (operand_i),
        .taken_o   (taken_o),
        .flags_o   (flags_o)
    );

    // {req[54:53], core[52:49], operand[48:17], taken[16], flags_after[15:0]}
    localparam int NV = 14;
    localparam logic [54:0] VEC [NV] = '{
        {2'b10, 4'd3,  32'h0000_0000, 1'b1, 16'h0008}, // R3 R4 trylock free
        {2'b10, 4'd3,  32'h0000_0000, 1'b0, 16'h0008}, // R4 trylock held
        {2'b01, 4'd3,  32'h0000_0000, 1'b1, 16'h0008}, // R5 lock held
        {2'b01, 4'd5,  32'h0000_0000, 1'b0, 16'h0028}, // R2 R5 lock free
        {2'b00, 4'd5,  32'hFFFF_FFFF, 1'b0, 16'h0028}, // R8 idle
        {2'b10, 4'd0,  32'h0000_0000, 1'b1, 16'h0029}, // R3
        {2'b10, 4'd15, 32'h0000_0000, 1'b1, 16'h8029}, // R3
        {2'b11, 4'd0,  32'h0000_0008, 1'b0, 16'h8021}, // R6 foreign clear
        {2'b11, 4'd7,  32'hFFFF_0000, 1'b0, 16'h8021}, // R7 upper half
        {2'b01, 4'd15, 32'h0000_0000, 1'b1, 16'h8021}, // R5
        {2'b11, 4'd9,  32'h0000_8001, 1'b0, 16'h0020}, // R6 two bits
        {2'b10, 4'd5,  32'h0000_0000, 1'b0, 16'h0020}, // R4 held
        {2'b11, 4'd5,  32'h0000_FFFF, 1'b0, 16'h0000}, // R6 self clear
        {2'b01, 4'd3,  32'h0000_0000, 1'b0, 16'h0008}  // R2 R5
    };

    task automatic check_taken(input logic exp, input string tag);
        checks++;
        if (taken_o !== exp) begin
            fails++;
            $display("FAIL %s taken actual=%b expected=%b", tag, taken_o, exp);
        end
    endtask

    task automatic check_flags(input logic [15:0] exp, input string tag);
        checks++;
        if (flags_o !== exp) begin
            fails++;
            $display("FAIL %s flags actual=%h expected=%h", tag, flags_o, exp);
        end
    endtask

    task automatic apply(input logic [1:0] r, input logic [3:0] c,
                         input logic [31:0] op);
        @(negedge clk);
        req_i = r;
        core_i = c;
        operand_i = op;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check_flags(16'h0000, "R1 reset state");

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][54:53], VEC[i][52:49], VEC[i][48:17]);
            check_taken(VEC[i][16], $sformatf("R4/R5/R8 vector %0d", i));
            @(posedge clk);
            #1;
            check_flags(VEC[i][15:0], $sformatf("R2/R3/R6/R7 vector %0d", i));
        end

        // Idle with busy operand must hold (R8)
        apply(2'b00, 4'd3, 32'h0000_FFFF);
        check_taken(1'b0, "R8 idle taken");
        @(posedge clk);
        #1;
        check_flags(16'h0008, "R8 idle hold");

        // Raise several flags then reset mid-run (R1)
        apply(2'b10, 4'd10, 32'h0);
        @(posedge clk);
        #1;
        check_flags(16'h0408, "R3 second flag");
        @(negedge clk);
        req_i = 2'b00;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check_flags(16'h0000, "R1 mid-run reset");
        @(negedge clk);
        rst = 1'b0;
        apply(2'b10, 4'd10, 32'h0);
        check_taken(1'b1, "R4 after reset");
        @(negedge clk);
        req_i = 2'b00;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #20000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule